// File: doc/BRIEF.md
# Linked-List Block Mover

This engine copies blocks of 32-bit words from a source bus into local memory with no processor help. Software writes the address of the first command descriptor and a start bit. From then on the engine runs the whole chain as one transaction. For each descriptor it reads the five descriptor words from memory, performs the transfer the descriptor asks for, and then follows the link to the next descriptor. It stops after a descriptor that carries the final flag, or at the first source bus error.

Each descriptor occupies five consecutive words at its byte address: +0 source address, +4 destination address, +8 word count (the low 16 bits are used), +12 control, +16 link to the next descriptor. The control word holds the cycle-type code in bits 5:0, the burst flag in bit 8 and the final flag in bit 9. In single mode every word is a separate source cycle that presents its own address. In burst mode only the first beat marks its address as valid, and both sides step the address by 4 on each later beat.

The controller runs through these states. IDLE goes to FETCH_RD when it accepts a start. FETCH_RD goes to FETCH_CAP. FETCH_CAP goes back to FETCH_RD until it has captured the fifth word, then goes to EVAL. EVAL goes to NEXT if the count is zero and to SRC otherwise. SRC goes to WR on an acknowledge and to IDLE on an error. WR goes to SRC while words remain and to NEXT after the last word. NEXT goes to IDLE when the final flag is set and to FETCH_RD otherwise.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset all status bits are 0, irq is low, and neither src_req nor mem_en is asserted while the engine is not busy.
- R2: A write to register 1 with bit 0 set while the engine is idle starts a chain at the address held in register 0. It clears the done and error bits and sets busy (status bit 0).
- R3: In single mode, beat k of a descriptor is a source cycle with src_addr_vld=1, src_addr = source+4k and src_am = control bits 5:0. The returned word is written to destination+4k.
- R4: In burst mode (control bit 8), only the first beat has src_addr_vld=1. The data of beat k comes from source+4k and is written to destination+4k.
- R5: After a descriptor the engine follows the link word. After a descriptor with control bit 9 set it clears busy and sets done (status bit 1).
- R6: A descriptor whose count is zero issues no source cycle and writes no memory, and the chain continues with its link.
- R7: A source error ends the chain at once. No word is written for the failed beat or after it. The error bit (status bit 2) is set, busy is cleared, done stays 0, and register 3 holds the address of the failing descriptor.
- R8: irq is high exactly when the interrupt enable (register 1 bit 1) is set and done or error is set.
- R9: Writing 1 to status bits 1, 2 or 3 clears them. When the engine sets a bit in the same cycle that software clears it, the set wins.
- R10: A start written while the engine is busy does not change the running chain and sets the sticky protocol-error bit (status bit 3).
- R11: src_req stays high, with src_addr and src_am unchanged, until src_ack or src_err arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 head, 1 control, 2 status, 3 failing descriptor |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt level |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read otherwise |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| src_req | output | 1 | Source cycle request |
| src_addr_vld | output | 1 | src_addr carries a new address for this beat |
| src_addr | output | 32 | Source byte address |
| src_am | output | 6 | Cycle-type code |
| src_ack | input | 1 | Source beat completed |
| src_err | input | 1 | Source beat failed |
| src_rdata | input | 32 | Source beat data |

## Verification
Two events can fall in the same cycle: the engine setting done in NEXT at the end of a chain, and a software write-one-to-clear of that same bit. The bench watches the memory port for the final data write of a burst descriptor. It then places a status clear so that it is sampled on the clock edge that leaves NEXT. The bench judges the outcome by reading status afterwards, and done must still read 1. A start that arrives while a chain is running is also exercised, and it must leave the transfer stream unchanged.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_RD,
        ST_FETCH_CAP,
        ST_EVAL,
        ST_SRC,
        ST_WR,
        ST_NEXT
    } eng_state_t;

    localparam int DESC_WORDS = 5;
    localparam int F_SRC = 0;
    localparam int F_DST = 1;
    localparam int F_CNT = 2;
    localparam int F_CTL = 3;
    localparam int F_NXT = 4;

    localparam logic [1:0] REG_HEAD = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_FAIL = 2'd3;

    localparam int CTL_BLK_BIT  = 8;
    localparam int CTL_LAST_BIT = 9;
endpackage

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          set_done,
    input  logic          set_err,
    input  logic [AW-1:0] fail_addr,
    output logic [AW-1:0] head,
    output logic          go,
    output logic          done_q,
    output logic          err_q,
    output logic          irq
);
    logic          irq_en_q;
    logic          proto_q;
    logic [AW-1:0] fail_q;
    logic          ctrl_wr, stat_wr, bad_go;

    assign ctrl_wr = we && (addr == REG_CTRL);
    assign stat_wr = we && (addr == REG_STAT);
    assign go      = ctrl_wr && wdata[0] && !busy;
    assign bad_go  = ctrl_wr && wdata[0] && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head     <= '0;
            irq_en_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            proto_q  <= 1'b0;
            fail_q   <= '0;
        end else begin
            if (we && addr == REG_HEAD) head <= wdata[AW-1:0];
            if (ctrl_wr) irq_en_q <= wdata[1];
            done_q  <= (done_q  && !(stat_wr && wdata[1]) && !go) || set_done;
            err_q   <= (err_q   && !(stat_wr && wdata[2]) && !go) || set_err;
            proto_q <= (proto_q && !(stat_wr && wdata[3])) || bad_go;
            if (set_err) fail_q <= fail_addr;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_HEAD: rdata[AW-1:0] = head;
            REG_CTRL: rdata[1]      = irq_en_q;
            REG_STAT: rdata[3:0]    = {proto_q, err_q, done_q, busy};
            REG_FAIL: rdata[AW-1:0] = fail_q;
        endcase
    end

    assign irq = irq_en_q && (done_q || err_q);
endmodule

// File: rtl/dma_beat_track.sv
module dma_beat_track #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic          last_beat
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            left_q  <= '0;
        end else if (load) begin
            src_ptr <= src_in;
            dst_ptr <= dst_in;
            left_q  <= cnt_in;
        end else if (step) begin
            src_ptr <= src_ptr + AW'(WB);
            dst_ptr <= dst_ptr + AW'(WB);
            left_q  <= left_q - 1'b1;
        end
    end

    assign last_beat = (left_q == CW'(1));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int AMW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           csr_we,
    input  logic [1:0]     csr_addr,
    input  logic [DW-1:0]  csr_wdata,
    output logic [DW-1:0]  csr_rdata,
    output logic           irq,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           src_req,
    output logic           src_addr_vld,
    output logic [AW-1:0]  src_addr,
    output logic [AMW-1:0] src_am,
    input  logic           src_ack,
    input  logic           src_err,
    input  logic [DW-1:0]  src_rdata
);
    localparam int WB = DW / 8;
    localparam int FW = $clog2(DESC_WORDS);

    eng_state_t    state_q, state_d;
    logic [AW-1:0] cur_desc_q;
    logic [FW-1:0] fidx_q;
    logic [DW-1:0] desc_q [DESC_WORDS];
    logic          first_q;
    logic [DW-1:0] beat_q;

    logic          busy, go, done_q, err_q;
    logic          set_done, set_err;
    logic [AW-1:0] head;
    logic [AW-1:0] src_ptr, dst_ptr;
    logic          last_beat;
    logic          d_blk, d_last, d_empty;

    assign busy    = (state_q != ST_IDLE);
    assign d_blk   = desc_q[F_CTL][CTL_BLK_BIT];
    assign d_last  = desc_q[F_CTL][CTL_LAST_BIT];
    assign d_empty = (desc_q[F_CNT][CW-1:0] == '0);

    dma_csr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr),
        .wdata(csr_wdata), .rdata(csr_rdata), .busy(busy),
        .set_done(set_done), .set_err(set_err), .fail_addr(cur_desc_q),
        .head(head), .go(go), .done_q(done_q), .err_q(err_q), .irq(irq)
    );

    dma_beat_track #(.AW(AW), .CW(CW), .WB(WB)) u_track (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_EVAL), .step(state_q == ST_WR),
        .src_in(desc_q[F_SRC][AW-1:0]), .dst_in(desc_q[F_DST][AW-1:0]),
        .cnt_in(desc_q[F_CNT][CW-1:0]),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .last_beat(last_beat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = ST_FETCH_RD;
            ST_FETCH_RD:  state_d = ST_FETCH_CAP;
            ST_FETCH_CAP: state_d = (fidx_q == FW'(DESC_WORDS-1)) ? ST_EVAL : ST_FETCH_RD;
            ST_EVAL:      state_d = d_empty ? ST_NEXT : ST_SRC;
            ST_SRC: begin
                if (src_err)      state_d = ST_IDLE;
                else if (src_ack) state_d = ST_WR;
            end
            ST_WR:        state_d = last_beat ? ST_NEXT : ST_SRC;
            ST_NEXT:      state_d = d_last ? ST_IDLE : ST_FETCH_RD;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_desc_q <= '0;
            fidx_q     <= '0;
            first_q    <= 1'b0;
            beat_q     <= '0;
            for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    cur_desc_q <= head;
                    fidx_q     <= '0;
                end
                ST_FETCH_CAP: begin
                    for (int i = 0; i < DESC_WORDS; i++)
                        if (fidx_q == FW'(i)) desc_q[i] <= mem_rdata;
                    fidx_q <= fidx_q + 1'b1;
                end
                ST_EVAL: first_q <= 1'b1;
                ST_SRC:  if (src_ack && !src_err) beat_q <= src_rdata;
                ST_WR:   first_q <= 1'b0;
                ST_NEXT: begin
                    cur_desc_q <= desc_q[F_NXT][AW-1:0];
                    fidx_q     <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = dst_ptr;
        mem_wdata    = beat_q;
        src_req      = 1'b0;
        src_addr_vld = 1'b0;
        src_addr     = src_ptr;
        src_am       = desc_q[F_CTL][AMW-1:0];
        set_done     = 1'b0;
        set_err      = 1'b0;
        unique case (state_q)
            ST_FETCH_RD: begin
                mem_en   = 1'b1;
                mem_addr = cur_desc_q + AW'(fidx_q) * AW'(WB);
            end
            ST_SRC: begin
                src_req      = 1'b1;
                src_addr_vld = !d_blk || first_q;
                set_err      = src_err;
            end
            ST_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_NEXT: set_done = d_last;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
    parameter int AW  = 32,
    parameter int AMW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done_q,
    input logic           err_q,
    input logic           src_req,
    input logic           src_ack,
    input logic           src_err,
    input logic [AW-1:0]  src_addr,
    input logic [AMW-1:0] src_am,
    input logic           mem_en,
    input logic           mem_we
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(src_req || mem_en)); // R1

    AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $past(src_req && src_ack)); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !busy); // R5

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && src_err) |=> (!busy && err_q && !done_q)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_ack && !src_err) |=> (src_req && $stable(src_addr) && $stable(src_am))); // R11
endmodule

bind dma_chain_engine dma_chain_checker #(.AW(AW), .AMW(AMW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_q(done_q), .err_q(err_q),
    .src_req(src_req), .src_ack(src_ack), .src_err(src_err),
    .src_addr(src_addr), .src_am(src_am), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/sim_dma_chain_engine.sv
`timescale 1ns/1ps
module sim_dma_chain_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        src_req, src_addr_vld;
    logic [31:0] src_addr;
    logic [5:0]  src_am;
    logic        src_ack = 1'b0, src_err = 1'b0;
    logic [31:0] src_rdata = '0;

    always #2.5 clk = ~clk;

    dma_chain_engine u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_req(src_req), .src_addr_vld(src_addr_vld), .src_addr(src_addr),
        .src_am(src_am), .src_ack(src_ack), .src_err(src_err), .src_rdata(src_rdata)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [31:0] bmem [0:4095];
    int          lat = 0;
    int          wait_cnt = 0;
    logic [31:0] resp_ptr = '0;
    logic [31:0] err_addr = 32'hFFFF_FFF0;

    bit          q_vld [$];
    logic [31:0] q_sa  [$];
    logic [5:0]  q_am  [$];
    logic [31:0] q_wa  [$];
    logic [31:0] q_wd  [$];

    function automatic logic [31:0] src_word(logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_en && mem_we) bmem[mem_addr[13:2]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= bmem[mem_addr[13:2]];
    end

    // source responder, keeps its own burst address
    always @(posedge clk) begin
        logic [31:0] ra;
        src_ack <= 1'b0;
        src_err <= 1'b0;
        if (src_req && !src_ack && !src_err) begin
            if (wait_cnt >= lat) begin
                wait_cnt = 0;
                ra = src_addr_vld ? src_addr : resp_ptr;
                resp_ptr <= ra + 32'd4;
                if (ra == err_addr) src_err <= 1'b1;
                else begin
                    src_ack   <= 1'b1;
                    src_rdata <= src_word(ra);
                end
            end else wait_cnt = wait_cnt + 1;
        end
    end

    // reference comparison each clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (src_req && (src_ack || src_err)) begin
                if (q_vld.size() == 0) chk(0, "R6 unexpected source beat", src_addr, 0);
                else begin
                    bit ev; logic [31:0] ea; logic [5:0] em;
                    ev = q_vld.pop_front(); ea = q_sa.pop_front(); em = q_am.pop_front();
                    chk(src_addr_vld == ev, "R4 address-valid flag", {31'd0, src_addr_vld}, {31'd0, ev});
                    if (ev) chk(src_addr == ea, "R3 source address", src_addr, ea);
                    chk(src_am == em, "R3 cycle type", {26'd0, src_am}, {26'd0, em});
                end
            end
            if (mem_en && mem_we) begin
                if (q_wa.size() == 0) chk(0, "R7 unexpected memory write", mem_addr, 0);
                else begin
                    logic [31:0] ea, ed;
                    ea = q_wa.pop_front(); ed = q_wd.pop_front();
                    chk(mem_addr == ea, "R3 write address", mem_addr, ea);
                    chk(mem_wdata == ed, "R4 write data", mem_wdata, ed);
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            chk(0, "watchdog", 0, 0);
            summary();
            $finish;
        end
    end

    task automatic csr_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            csr_read(2'd2, s);
            if (!s[0]) break;
        end
    endtask

    task automatic put_desc(int a, logic [31:0] s, logic [31:0] d, int n,
                            logic [5:0] am, bit blk, bit last, logic [31:0] nx);
        bmem[(a >> 2) + 0] = s;
        bmem[(a >> 2) + 1] = d;
        bmem[(a >> 2) + 2] = n;
        bmem[(a >> 2) + 3] = {22'd0, last, blk, 2'd0, am};
        bmem[(a >> 2) + 4] = nx;
    endtask

    // stop: beat index that fails (n for none)
    task automatic exp_desc(logic [31:0] s, logic [31:0] d, int n, logic [5:0] am, bit blk, int stop);
        for (int k = 0; k < n && k <= stop; k++) begin
            q_vld.push_back(!blk || k == 0);
            q_sa.push_back(s + 4 * k);
            q_am.push_back(am);
            if (k < stop) begin
                q_wa.push_back(d + 4 * k);
                q_wd.push_back(src_word(s + 4 * k));
            end
        end
    endtask

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 4096; i++) bmem[i] = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        csr_read(2'd2, r);
        chk(r == 0, "R1 status after reset", r, 0);
        chk(irq == 0 && src_req == 0 && mem_en == 0, "R1 outputs quiet", {irq, src_req, mem_en}, 0);

        // chain: single, empty, burst
        put_desc(32'h100, 32'h8000_0000, 32'h1000, 3, 6'h09, 0, 0, 32'h200);
        put_desc(32'h200, 32'h8800_0000, 32'h1800, 0, 6'h09, 0, 0, 32'h300); // R6
        put_desc(32'h300, 32'h9000_0000, 32'h2000, 4, 6'h08, 1, 1, 32'h0);
        exp_desc(32'h8000_0000, 32'h1000, 3, 6'h09, 0, 3);
        exp_desc(32'h9000_0000, 32'h2000, 4, 6'h08, 1, 4);
        lat = 1;
        csr_write(2'd0, 32'h100);
        csr_write(2'd1, 32'h3);          // R2 start with irq enable
        csr_read(2'd2, r);
        chk(r[0] == 1, "R2 busy after start", r, 1);
        csr_write(2'd1, 32'h3);          // R10 start while busy
        wait_idle();
        csr_read(2'd2, r);
        chk(r[3:0] == 4'b1010, "R5 R10 status after chain", r, 32'hA);
        chk(q_wa.size() == 0 && q_vld.size() == 0, "R5 whole chain walked", q_wa.size(), 0);
        chk(bmem[32'h1800 >> 2] == 32'hDEAD_BEEF, "R6 empty descriptor wrote nothing", bmem[32'h1800 >> 2], 32'hDEAD_BEEF);
        chk(bmem[32'h200C >> 2] == src_word(32'h9000_000C), "R4 last burst word stored", bmem[32'h200C >> 2], src_word(32'h9000_000C));
        chk(irq == 1, "R8 irq on done", irq, 1);
        csr_write(2'd2, 32'hE);          // R9 clear all
        csr_read(2'd2, r);
        chk(r == 0, "R9 write-one clear", r, 0);
        chk(irq == 0, "R8 irq drops after clear", irq, 0);

        // R7 error on third beat
        put_desc(32'h400, 32'hA000_0000, 32'h3000, 4, 6'h09, 0, 0, 32'h500);
        put_desc(32'h500, 32'hB000_0000, 32'h3800, 2, 6'h09, 0, 1, 32'h0);
        err_addr = 32'hA000_0008;
        exp_desc(32'hA000_0000, 32'h3000, 4, 6'h09, 0, 2);
        lat = 2;
        csr_write(2'd0, 32'h400);
        csr_write(2'd1, 32'h3);
        wait_idle();
        csr_read(2'd2, r);
        chk(r[3:0] == 4'b0100, "R7 error status", r, 32'h4);
        csr_read(2'd3, r);
        chk(r == 32'h400, "R7 failing descriptor", r, 32'h400);
        chk(bmem[32'h3008 >> 2] == 32'hDEAD_BEEF, "R7 failed beat not written", bmem[32'h3008 >> 2], 32'hDEAD_BEEF);
        chk(bmem[32'h3800 >> 2] == 32'hDEAD_BEEF, "R7 chain stopped", bmem[32'h3800 >> 2], 32'hDEAD_BEEF);
        chk(irq == 1, "R8 irq on error", irq, 1);
        chk(q_vld.size() == 0 && q_wa.size() == 0, "R7 beats consumed", q_vld.size(), 0);
        csr_write(2'd2, 32'h4);
        err_addr = 32'hFFFF_FFF0;

        // R9 collision: clear arrives in the cycle done is set
        put_desc(32'h600, 32'hC000_0000, 32'h3C00, 2, 6'h08, 1, 1, 32'h0);
        exp_desc(32'hC000_0000, 32'h3C00, 2, 6'h08, 1, 2);
        lat = 0;
        csr_write(2'd0, 32'h600);
        csr_write(2'd1, 32'h1);          // irq disabled
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (mem_en && mem_we && mem_addr == 32'h3C04) break;
        end
        @(posedge clk);
        csr_write(2'd2, 32'h2);
        csr_read(2'd2, r);
        chk(r[1] == 1, "R9 set wins over clear", r, 32'h2);
        chk(irq == 0, "R8 irq masked", irq, 0);
        csr_write(2'd2, 32'h2);
        csr_read(2'd2, r);
        chk(r == 0, "R9 clear afterwards", r, 0);

        summary();
        $finish;
    end
endmodule